// File: doc/BRIEF.md
# Suspect Switch Diagnosis Tally

This block sits at the receiving I/O node of a small mesh network and tries to locate one faulty router from end-to-end results. For each packet that reaches the node, the block is handed the source coordinates, the destination coordinates and a verdict: good or bad. The verdict comes from the sequence-number and CRC checks upstream. Because the mesh routes every packet in X first and then in Y, the block can rebuild the packet's route from its two end coordinates. It then adjusts a suspicion score for every router the packet passed through between its two ends.

A bad packet raises the score of each intermediate router. A good packet clears those routers and marks them as proven good, which keeps their score at zero until the next clear. The two end routers are never scored, so a fault in an I/O router cannot be found this way. After each update the block reports the router with the highest score. When exactly one router holds that score, the block flags the report as a valid diagnosis. Working out verdicts and carrying packets through the mesh are outside the block.

The mesh width and height are parameters (3x3 by default). A router's index is y*MESH_X + x. The block assumes that every coordinate it receives lies inside the mesh.

Top module: `sw_diag_tally`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), busy is 0, diag_valid is 0 and diag_idx is 0.
- R2: A verdict presented with pkt_vld high while busy is low is accepted. The route is rebuilt by first stepping x one unit at a time toward dst_x, then stepping y toward dst_y. Each router strictly between the source and the destination on that route is updated.
- R3: The source router and the destination router of a packet are never scored. A packet between adjacent routers, or with src equal to dst, changes no score.
- R4: A bad packet (pkt_bad = 1) adds one to the 4-bit score of each on-route router that is not proven good. A score stops at 15.
- R5: A good packet (pkt_bad = 0) sets each on-route router's score to 0 and marks it proven good. A later bad packet leaves that router's score at 0.
- R6: diag_idx is the index (y*MESH_X + x) of the router with the highest score. When several routers share that score, the lowest index is reported.
- R7: diag_valid is 1 only when exactly one router holds the highest score. When all scores are 0, diag_valid is 0.
- R8: After acceptance, busy is high for max(1, |dst_x-src_x| + |dst_y-src_y|) cycles. While busy is high, pkt_vld is ignored.
- R9: A clear pulse (clr high at an edge) sets all scores to 0, removes all proven-good marks and abandons any route walk in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of scores, marks and walk |
| pkt_vld | input | 1 | Verdict present this cycle |
| pkt_bad | input | 1 | 1 = packet failed its end-to-end check |
| src_x | input | XW | Source router column |
| src_y | input | YW | Source router row |
| dst_x | input | XW | Destination router column |
| dst_y | input | YW | Destination router row |
| busy | output | 1 | Route walk in progress; verdicts not taken |
| diag_idx | output | IW | Index of the highest-scoring router |
| diag_valid | output | 1 | One router strictly leads all others |

## Verification
Directed packets along single rows, single columns and L-shaped routes show whether the rebuilt route turns at the correct corner, because only a correct XY route singles out the expected intermediate router. Adjacent and self-addressed packets separate correct end-router exclusion from off-by-one walks. Long runs of bad packets on two disjoint routes drive both scores to 15 and produce a tie, which would not appear without saturation. Good packets followed by bad ones on the same route show whether the proven-good mark holds. Random traffic from a fixed seed, with mixed verdicts, compares every diagnosis and every busy length against a reference model in the bench.

// File: rtl/swdiag_pkg.sv
package swdiag_pkg;

  // Width needed to hold values 0 .. n-1, never below one bit.
  function automatic int bits_for(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/swdiag_walker.sv
// Rebuilds an XY route one hop per cycle and emits one score update per
// intermediate router.
module swdiag_walker #(
  parameter int MESH_X = 3,
  parameter int MESH_Y = 3,
  parameter int XW     = 2,
  parameter int YW     = 2,
  parameter int IW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic          bad_in,
  input  logic [XW-1:0] sx,
  input  logic [YW-1:0] sy,
  input  logic [XW-1:0] tx,
  input  logic [YW-1:0] ty,
  output logic          active,
  output logic          upd_en,
  output logic          upd_bad,
  output logic [IW-1:0] upd_idx
);

  logic [XW-1:0] cur_x, tgt_x, nxt_x;
  logic [YW-1:0] cur_y, tgt_y, nxt_y;
  logic          verdict_bad;
  logic          at_end;

  // Next hop: X is resolved fully before Y moves.
  always_comb begin
    nxt_x = cur_x;
    nxt_y = cur_y;
    if (cur_x != tgt_x) begin
      nxt_x = (cur_x < tgt_x) ? cur_x + XW'(1) : cur_x - XW'(1);
    end else if (cur_y != tgt_y) begin
      nxt_y = (cur_y < tgt_y) ? cur_y + YW'(1) : cur_y - YW'(1);
    end
    at_end = (nxt_x == tgt_x) && (nxt_y == tgt_y);
  end

  assign upd_en  = active && !at_end;
  assign upd_bad = verdict_bad;
  assign upd_idx = IW'(nxt_y) * IW'(MESH_X) + IW'(nxt_x);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active      <= 1'b0;
      cur_x       <= '0;
      cur_y       <= '0;
      tgt_x       <= '0;
      tgt_y       <= '0;
      verdict_bad <= 1'b0;
    end else if (active) begin
      if (at_end) begin
        active <= 1'b0;
      end else begin
        cur_x <= nxt_x;
        cur_y <= nxt_y;
      end
    end else if (start) begin
      active      <= 1'b1;
      cur_x       <= sx;
      cur_y       <= sy;
      tgt_x       <= tx;
      tgt_y       <= ty;
      verdict_bad <= bad_in;
    end
  end

  // MESH_Y fixes the legal row range; the walker itself needs only widths.
  localparam int ROWS_SEEN = MESH_Y;
  if (ROWS_SEEN < 1) begin : g_bad_mesh
    initial $display("mesh height must be at least one");
  end

endmodule

// File: rtl/swdiag_scores.sv
// Per-router saturating suspicion scores with sticky proven-good marks.
module swdiag_scores #(
  parameter int NODES = 9,
  parameter int SW    = 4,
  parameter int IW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd_en,
  input  logic              upd_bad,
  input  logic [IW-1:0]     upd_idx,
  output logic [NODES*SW-1:0] scores
);

  localparam logic [SW-1:0] SAT = '1;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [SW-1:0] score;
    logic          proven;
    logic          hit;

    assign hit = upd_en && (upd_idx == IW'(n));

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        score  <= '0;
        proven <= 1'b0;
      end else if (hit) begin
        if (!upd_bad) begin
          score  <= '0;
          proven <= 1'b1;
        end else if (!proven && score != SAT) begin
          score <= score + SW'(1);
        end
      end
    end

    assign scores[n*SW +: SW] = score;
  end

endmodule

// File: rtl/swdiag_argmax.sv
// Highest score, lowest index on ties, with a strict-leader flag.
module swdiag_argmax #(
  parameter int NODES = 9,
  parameter int SW    = 4,
  parameter int IW    = 4
) (
  input  logic [NODES*SW-1:0] scores,
  output logic [IW-1:0]       best_idx,
  output logic                sole_lead
);

  logic [SW-1:0] best_val;
  logic          tied;

  always_comb begin
    best_val = scores[SW-1:0];
    best_idx = '0;
    tied     = 1'b0;
    for (int i = 1; i < NODES; i++) begin
      if (scores[i*SW +: SW] > best_val) begin
        best_val = scores[i*SW +: SW];
        best_idx = IW'(i);
        tied     = 1'b0;
      end else if (scores[i*SW +: SW] == best_val) begin
        tied = 1'b1;
      end
    end
    sole_lead = !tied;
  end

endmodule

// File: rtl/sw_diag_tally.sv
module sw_diag_tally #(
  parameter int MESH_X  = 3,
  parameter int MESH_Y  = 3,
  parameter int SCORE_W = 4,
  localparam int NODES  = MESH_X * MESH_Y,
  localparam int XW     = swdiag_pkg::bits_for(MESH_X),
  localparam int YW     = swdiag_pkg::bits_for(MESH_Y),
  localparam int IW     = swdiag_pkg::bits_for(NODES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          pkt_vld,
  input  logic          pkt_bad,
  input  logic [XW-1:0] src_x,
  input  logic [YW-1:0] src_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          busy,
  output logic [IW-1:0] diag_idx,
  output logic          diag_valid
);

  logic                     upd_en, upd_bad;
  logic [IW-1:0]            upd_idx;
  logic [NODES*SCORE_W-1:0] scores;
  logic [IW-1:0]            lead_idx;
  logic                     lead_sole;

  swdiag_walker #(
    .MESH_X(MESH_X), .MESH_Y(MESH_Y), .XW(XW), .YW(YW), .IW(IW)
  ) u_walk (
    .clk(clk), .rst(rst), .clr(clr),
    .start(pkt_vld), .bad_in(pkt_bad),
    .sx(src_x), .sy(src_y), .tx(dst_x), .ty(dst_y),
    .active(busy), .upd_en(upd_en), .upd_bad(upd_bad), .upd_idx(upd_idx)
  );

  swdiag_scores #(
    .NODES(NODES), .SW(SCORE_W), .IW(IW)
  ) u_scores (
    .clk(clk), .rst(rst), .clr(clr),
    .upd_en(upd_en), .upd_bad(upd_bad), .upd_idx(upd_idx),
    .scores(scores)
  );

  swdiag_argmax #(
    .NODES(NODES), .SW(SCORE_W), .IW(IW)
  ) u_pick (
    .scores(scores), .best_idx(lead_idx), .sole_lead(lead_sole)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_idx   <= '0;
      diag_valid <= 1'b0;
    end else begin
      diag_idx   <= lead_idx;
      diag_valid <= lead_sole;
    end
  end

endmodule

// File: rtl/sw_diag_tally_chk.sv
module sw_diag_tally_chk #(
  parameter int NODES = 9,
  parameter int IW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          pkt_vld,
  input logic          busy,
  input logic          upd_en,
  input logic [IW-1:0] diag_idx,
  input logic          diag_valid
);

  // R8
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && !busy && !clr) |=> busy);

  // R8
  busy_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pkt_vld));

  // R9
  clear_idles_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !busy);

  // R9
  clear_drops_lead_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 (!diag_valid || NODES == 1));

  // R2
  update_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> busy);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(diag_idx) < NODES);

endmodule

bind sw_diag_tally sw_diag_tally_chk #(.NODES(NODES), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .pkt_vld(pkt_vld), .busy(busy),
  .upd_en(upd_en), .diag_idx(diag_idx), .diag_valid(diag_valid)
);

// File: tb/sw_diag_tally_test.sv
module sw_diag_tally_test;
  localparam int MX = 3, MY = 3, N = MX * MY;

  logic clk = 0, rst = 1, clr = 0, pkt_vld = 0, pkt_bad = 0;
  logic [1:0] src_x = 0, src_y = 0, dst_x = 0, dst_y = 0;
  logic busy, diag_valid;
  logic [3:0] diag_idx;

  int checks = 0, fails = 0;
  int score_m [N];
  bit proven_m [N];

  sw_diag_tally uut (
    .clk(clk), .rst(rst), .clr(clr), .pkt_vld(pkt_vld), .pkt_bad(pkt_bad),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .busy(busy), .diag_idx(diag_idx), .diag_valid(diag_valid)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < N; i++) begin score_m[i] = 0; proven_m[i] = 0; end
  endfunction

  function automatic void model_apply(int sx, int sy, int tx, int ty, bit b);
    int x = sx, y = sy;
    for (int k = 0; k < 8; k++) begin
      if (x != tx) x += (x < tx) ? 1 : -1;
      else if (y != ty) y += (y < ty) ? 1 : -1;
      if (x == tx && y == ty) break;
      if (!b) begin score_m[y*MX+x] = 0; proven_m[y*MX+x] = 1; end
      else if (!proven_m[y*MX+x] && score_m[y*MX+x] < 15) score_m[y*MX+x]++;
    end
  endfunction

  function automatic int exp_idx();
    int bi = 0;
    for (int i = 1; i < N; i++) if (score_m[i] > score_m[bi]) bi = i;
    return bi;
  endfunction

  function automatic int exp_valid();
    int c = 0;
    int bv = score_m[exp_idx()];
    for (int i = 0; i < N; i++) if (score_m[i] == bv) c++;
    return (c == 1) ? 1 : 0;
  endfunction

  function automatic int abs_i(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Send one verdict, check busy length (R8), then the diagnosis (R6, R7).
  task automatic send(input int sx, input int sy, input int tx, input int ty,
                      input bit b, input string req);
    int cnt = 0;
    int hops = abs_i(tx - sx) + abs_i(ty - sy);
    @(negedge clk);
    src_x = 2'(sx); src_y = 2'(sy); dst_x = 2'(tx); dst_y = 2'(ty);
    pkt_bad = b; pkt_vld = 1;
    @(negedge clk);
    pkt_vld = 0;
    while (busy && cnt < 20) begin cnt++; @(negedge clk); end
    chk({req, " R8 busy length"}, cnt, (hops < 1) ? 1 : hops);
    model_apply(sx, sy, tx, ty, b);
    @(negedge clk);
    chk({req, " R6 diag_idx"}, diag_idx, exp_idx());
    chk({req, " R7 diag_valid"}, diag_valid, exp_valid());
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    model_clear();
    @(negedge clk);
  endtask

  initial begin
    int seed = 32'h5eed;
    int dummy;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 diag_valid", diag_valid, 0);
    chk("R1 diag_idx", diag_idx, 0);

    // R2 row route (0,0)->(2,0): only router 1 is scored
    send(0, 0, 2, 0, 1, "R2 row");
    chk("R2 row lead", diag_idx, 1);
    // R2 L route (0,0)->(2,2): turns at (2,0); routers 1,2,5 scored
    do_clear();
    send(0, 0, 2, 2, 1, "R2 L");
    send(2, 0, 2, 2, 1, "R2 col");
    chk("R2 corner router 5 leads", diag_idx, 5);
    chk("R2 corner valid", diag_valid, 1);

    // R3 adjacent and self-addressed packets change nothing
    do_clear();
    send(1, 1, 2, 1, 1, "R3 adjacent");
    send(1, 1, 1, 1, 1, "R3 self");
    chk("R3 no lead", diag_valid, 0);

    // R4 saturation: two routers reach 15 and tie
    do_clear();
    repeat (20) send(0, 0, 2, 0, 1, "R4 row0");
    repeat (16) send(0, 1, 2, 1, 1, "R4 row1");
    chk("R4 saturated tie valid", diag_valid, 0);
    chk("R4 saturated tie idx", diag_idx, 1);

    // R5 good clears and proves
    do_clear();
    send(0, 0, 2, 0, 1, "R5 bad");
    send(0, 0, 2, 0, 0, "R5 good");
    send(0, 0, 2, 0, 1, "R5 bad again");
    send(0, 2, 2, 2, 1, "R5 other");
    chk("R5 proven stays zero, router 7 leads", diag_idx, 7);

    // R8 verdict during busy ignored
    do_clear();
    @(negedge clk);
    src_x = 0; src_y = 0; dst_x = 2; dst_y = 2; pkt_bad = 1; pkt_vld = 1;
    @(negedge clk);
    src_x = 0; src_y = 2; dst_x = 2; dst_y = 2;
    repeat (2) @(negedge clk);
    pkt_vld = 0;
    while (busy) @(negedge clk);
    model_apply(0, 0, 2, 2, 1);
    @(negedge clk);
    chk("R8 ignored idx", diag_idx, exp_idx());
    chk("R8 ignored valid", diag_valid, exp_valid());
    send(0, 1, 0, 2, 1, "R8 probe");
    chk("R8 router 7 untouched", diag_idx, exp_idx());

    // R9 clear mid-walk abandons it
    @(negedge clk);
    src_x = 0; src_y = 0; dst_x = 2; dst_y = 2; pkt_bad = 1; pkt_vld = 1;
    @(negedge clk); pkt_vld = 0;
    clr = 1;
    @(negedge clk); clr = 0;
    model_clear();
    chk("R9 busy dropped", busy, 0);
    repeat (3) @(negedge clk);
    chk("R9 no lead", diag_valid, 0);
    chk("R9 idx", diag_idx, 0);

    // Random traffic
    dummy = $urandom(seed);
    for (int p = 0; p < 400; p++) begin
      int a = $urandom_range(0, 2), bq = $urandom_range(0, 2);
      int c = $urandom_range(0, 2), d = $urandom_range(0, 2);
      bit bb = ($urandom_range(0, 9) < 8);
      if (p % 100 == 99) do_clear();
      send(a, bq, c, d, bb, "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule